// File: doc/BRIEF.md
# Folded Single-Port Word Memory

This block is a synchronous single-port memory that stores 2048 words of 16 bits. Inside, the words sit in a folded array of 256 rows, each 128 bits wide. The upper address bits drive a row decoder, which raises one wordline. The whole selected row is fetched. A bank of 16 eight-to-one column selectors then picks the addressed word out of that row. The bits of one word are interleaved across the row: bit i of the word in column group c lives at row bit 8*i + c.

When the chip is enabled and write enable is high, the block performs a read-modify-write of the selected row. Only the 16 bits of the addressed column group take the new data, and the other 112 bits are written back unchanged. When the chip is enabled and write enable is low, the block reads, and the output register shows the word one clock later. The output register keeps its value through write cycles and idle cycles.

Top module: `fold_sram_top`

## Requirements
- R1: Each of the 2048 addresses holds its own 16-bit word. Address bits [10:3] choose the row and bits [2:0] choose the column group within that row.
- R2: A write replaces only the addressed word. The seven other words that share its row keep their contents.
- R3: A read is a cycle with chipSel=1 and writeEn=0. The word stored at the address appears on dataOut after the next rising clock edge and stays there until the next read.
- R4: During a write cycle (chipSel=1, writeEn=1), dataOut keeps the value left by the last read.
- R5: While chipSel=0, no row is selected and nothing is written, whatever writeEn, addr and dataIn are. dataOut holds its value.
- R6: The row decoder raises exactly one of the 256 wordlines in every enabled cycle. An access never disturbs rows other than the addressed one.
- R7: While rstN is low, dataOut is cleared to zero.
- R8: A read in the cycle right after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| chipSel | input | 1 | Enables an access in this cycle |
| writeEn | input | 1 | Chooses write (1) or read (0) when chipSel is high |
| addr | input | 11 | Word address: [10:3] row, [2:0] column group |
| dataIn | input | 16 | Word to store on a write |
| dataOut | output | 16 | Registered read data |

## Verification
A full sweep writes every address and then reads every address back. Because each word holds distinct random data, this sweep exposes any aliasing in the row or column decode.

Directed patterns test the folding itself:
- All eight column groups of one row are filled, then a single group is rewritten and all eight are read back. This catches a write that is not limited to its own column group.
- The rows on either side of a written row are read back. This catches a decoder that raises more than one wordline.
- Disabled cycles with writeEn high show that nothing is stored and that dataOut holds its value.
- A write followed at once by a read of the same address checks that the read sees the new data.

A long random mix of reads, writes and idle cycles, compared against a flat reference array, covers the remaining interleavings.

// File: rtl/fold_sram_pkg.sv
package fold_sram_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic rdEn;
    logic wrEn;
  } memStrobe_t;

endpackage

// File: rtl/fold_sram_ctrl.sv
module fold_sram_ctrl
  import fold_sram_pkg::*;
(
  input  logic       chipSel,
  input  logic       writeEn,
  output memStrobe_t strb
);

  // The write is qualified by chip select; read is the enabled non-write case
  always_comb begin
    strb.rdEn = chipSel & ~writeEn;
    strb.wrEn = chipSel & writeEn;
  end

endmodule

// File: rtl/fold_row_decoder.sv
module fold_row_decoder #(
  parameter int ROW_COUNT = 256,
  parameter int ROW_W     = $clog2(ROW_COUNT)
) (
  input  logic                 enable,
  input  logic [ROW_W-1:0]     rowIdx,
  output logic [ROW_COUNT-1:0] wordLine
);

  // One comparator per row
  for (genvar r = 0; r < ROW_COUNT; r++) begin : gRow
    assign wordLine[r] = enable && (rowIdx == ROW_W'(r));
  end

endmodule

// File: rtl/fold_sram_datapath.sv
module fold_sram_datapath
  import fold_sram_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MUX_RATIO = 8,
  parameter int ROW_COUNT = 256,
  parameter int ADDR_W    = $clog2(ROW_COUNT * MUX_RATIO)
) (
  input  logic              clk,
  input  logic              rstN,
  input  memStrobe_t        strb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut
);

  localparam int COL_W   = $clog2(MUX_RATIO);
  localparam int ROW_W   = $clog2(ROW_COUNT);
  localparam int ROW_BITS = WORD_W * MUX_RATIO;

  logic [COL_W-1:0]     colIdx;
  logic [ROW_W-1:0]     rowIdx;
  logic [ROW_COUNT-1:0] wordLine;
  logic [ROW_BITS-1:0]  rowMem [ROW_COUNT];
  logic [ROW_BITS-1:0]  selRow;
  logic [ROW_BITS-1:0]  mergedRow;
  logic [WORD_W-1:0]    rdWord;

  assign colIdx = addr[COL_W-1:0];
  assign rowIdx = addr[ADDR_W-1:COL_W];

  fold_row_decoder #(
    .ROW_COUNT (ROW_COUNT),
    .ROW_W     (ROW_W)
  ) uDecoder (
    .enable   (strb.rdEn | strb.wrEn),
    .rowIdx   (rowIdx),
    .wordLine (wordLine)
  );

  // Wordline-gated row fetch (AND-OR across all rows)
  always_comb begin
    selRow = '0;
    for (int r = 0; r < ROW_COUNT; r++) begin
      if (wordLine[r]) selRow = selRow | rowMem[r];
    end
  end

  // Column multiplexers: word bit i from row bit MUX_RATIO*i + colIdx
  always_comb begin
    for (int i = 0; i < WORD_W; i++) begin
      rdWord[i] = selRow[i*MUX_RATIO + int'(colIdx)];
    end
  end

  // Merge the new slice into the fetched row
  always_comb begin
    mergedRow = selRow;
    for (int i = 0; i < WORD_W; i++) begin
      mergedRow[i*MUX_RATIO + int'(colIdx)] = dataIn[i];
    end
  end

  // Write back the whole row on the active wordline
  always_ff @(posedge clk) begin
    for (int r = 0; r < ROW_COUNT; r++) begin
      if (strb.wrEn && wordLine[r]) rowMem[r] <= mergedRow;
    end
  end

  // Output register, loaded only on reads
  always_ff @(posedge clk) begin
    if (!rstN)          dataOut <= '0;
    else if (strb.rdEn) dataOut <= rdWord;
  end

  // Decoder never raises more than one wordline
  assert_wl_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wordLine));

  // An enabled access raises exactly one wordline
  assert_wl_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn || strb.wrEn) |-> ($countones(wordLine) == 1));

  // Disabled cycle selects no row
  assert_wl_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdEn || strb.wrEn) |-> (wordLine == '0));

  // Output held across a write
  assert_hold_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> $stable(dataOut));

  // Output held across an idle cycle
  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdEn || strb.wrEn) |=> $stable(dataOut));

endmodule

// File: rtl/fold_sram_top.sv
module fold_sram_top
  import fold_sram_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int MUX_RATIO = 8,
  parameter int ROW_COUNT = 256,
  parameter int ADDR_W    = $clog2(ROW_COUNT * MUX_RATIO)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSel,
  input  logic              writeEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut
);

  memStrobe_t strb;

  fold_sram_ctrl uCtrl (
    .chipSel (chipSel),
    .writeEn (writeEn),
    .strb    (strb)
  );

  fold_sram_datapath #(
    .WORD_W    (WORD_W),
    .MUX_RATIO (MUX_RATIO),
    .ROW_COUNT (ROW_COUNT),
    .ADDR_W    (ADDR_W)
  ) uDatapath (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

endmodule

// File: tb/tb_fold_sram_top.sv
module tb_fold_sram_top;

  localparam int DEPTH = 2048;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chipSel = 1'b0;
  logic        writeEn = 1'b0;
  logic [10:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;

  logic [15:0] refMem [DEPTH];
  logic [15:0] expOut;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  fold_sram_top dut (
    .clk     (clk),
    .rstN    (rstN),
    .chipSel (chipSel),
    .writeEn (writeEn),
    .addr    (addr),
    .dataIn  (dataIn),
    .dataOut (dataOut)
  );

  task automatic checkOut(input string tag);
    checks++;
    if (dataOut !== expOut) begin
      fails++;
      $display("FAIL %s: dataOut=%h expected=%h (addr=%h)", tag, dataOut, expOut, addr);
    end
  endtask

  // Drives one cycle, advances the model, checks output 2 ns after the edge
  task automatic doCycle(input logic c, input logic w, input logic [10:0] a,
                         input logic [15:0] d, input string tag);
    chipSel = c; writeEn = w; addr = a; dataIn = d;
    @(posedge clk);
    if (c && !w) expOut = refMem[a];
    if (c && w)  refMem[a] = d;
    #2;
    checkOut(tag);
  endtask

  function automatic logic [10:0] mkAddr(input int row, input int col);
    return 11'((row << 3) | col);
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    void'($urandom(32'd1234));
    expOut = '0;

    // R7: reset clears the output
    repeat (3) @(posedge clk);
    #2;
    checkOut("R7 reset");
    @(negedge clk);
    rstN = 1'b1;

    // R1/R4: fill every word; output stays at the reset value during writes
    for (int a = 0; a < DEPTH; a++) begin
      doCycle(1'b1, 1'b1, 11'(a), 16'($urandom), "R4 hold on write");
    end

    // R1/R3: read back everything
    for (int a = 0; a < DEPTH; a++) begin
      doCycle(1'b1, 1'b0, 11'(a), 16'hFFFF, "R1 R3 full sweep read");
    end

    // R2: rewrite one column group, other groups in the row keep data
    for (int c = 0; c < 8; c++) doCycle(1'b1, 1'b1, mkAddr(77, c), 16'h1111 * 16'(c + 1), "R4 fill row");
    doCycle(1'b1, 1'b1, mkAddr(77, 5), 16'hBEEF, "R4 rewrite slice");
    for (int c = 0; c < 8; c++) doCycle(1'b1, 1'b0, mkAddr(77, c), 16'h0, "R2 row neighbours");

    // R6: neighbouring rows untouched by a write
    doCycle(1'b1, 1'b1, mkAddr(128, 3), 16'hA5A5, "R4 write mid row");
    for (int c = 0; c < 8; c++) begin
      doCycle(1'b1, 1'b0, mkAddr(127, c), 16'h0, "R6 row below");
      doCycle(1'b1, 1'b0, mkAddr(129, c), 16'h0, "R6 row above");
    end
    doCycle(1'b1, 1'b0, mkAddr(128, 3), 16'h0, "R6 written row");

    // R5: disabled cycles with write enable set store nothing, output holds
    doCycle(1'b1, 1'b0, 11'd300, 16'h0, "R3 prime output");
    for (int k = 0; k < 6; k++) doCycle(1'b0, 1'b1, 11'd300, 16'h5A00 + 16'(k), "R5 idle hold");
    doCycle(1'b0, 1'b0, 11'd301, 16'hDEAD, "R5 idle hold");
    doCycle(1'b1, 1'b0, 11'd300, 16'h0, "R5 no write while disabled");

    // R1: address extremes
    doCycle(1'b1, 1'b1, 11'd0, 16'h0001, "R4 corner write");
    doCycle(1'b1, 1'b1, 11'd2047, 16'h8000, "R4 corner write");
    doCycle(1'b1, 1'b0, 11'd0, 16'h0, "R1 lowest address");
    doCycle(1'b1, 1'b0, 11'd2047, 16'h0, "R1 highest address");

    // R8: read right after write to same address
    for (int k = 0; k < 8; k++) begin
      logic [10:0] ra;
      ra = 11'($urandom);
      doCycle(1'b1, 1'b1, ra, 16'($urandom), "R4 write before read");
      doCycle(1'b1, 1'b0, ra, 16'h0, "R8 read after write");
    end

    // Random mix of reads, writes and idles; row-local addresses favoured
    for (int k = 0; k < 6000; k++) begin
      int op;
      logic [10:0] ra;
      op = int'($urandom_range(0, 9));
      ra = ($urandom_range(0, 1) == 1) ? mkAddr(int'($urandom_range(40, 43)), int'($urandom_range(0, 7)))
                                      : 11'($urandom);
      if (op < 4)      doCycle(1'b1, 1'b1, ra, 16'($urandom), "R2 R4 random write");
      else if (op < 9) doCycle(1'b1, 1'b0, ra, 16'($urandom), "R1 R3 random read");
      else             doCycle(1'b0, 1'($urandom), ra, 16'($urandom), "R5 random idle");
    end

    // Final sweep confirms the whole array after the random mix
    for (int a = 0; a < DEPTH; a++) begin
      doCycle(1'b1, 1'b0, 11'(a), 16'h0, "R2 R6 final sweep");
    end

    finishRun();
  end

endmodule